// File: doc/BRIEF.md
# Carrier-Bus Slave Controller with Identification Words

This block is the slave side of a 16-bit, 8 MHz carrier bus on a small analog-output board. It watches two select strobes, one for identification space and one for I/O space, together with the read/write line, two byte-enable strobes and a word address. It answers every valid cycle with zero wait states.

Identification reads return words from a constant pattern that is computed inside the block. I/O cycles land in an eight-word map that is split between two quad converter devices. For each I/O cycle the block produces a one-clock chip select and a one-clock read or write strobe. The block also steers a pair of bus-coupling transceivers. It sets their direction, and it controls their output enable so that the host data bus is released in the same cycle the I/O select goes away.

Each cycle is acknowledged once. If the carrier holds the select asserted after the acknowledge, the block waits without starting another access and keeps its outputs where they are.

Top module: `iobus_slave`

## Requirements
- R1: While rst_n is low, and after it, until the first access: ack_n is 1, dac_cs_n is all ones, dac_rd_n and dac_wr_n are 1, xcvr_oe_n is 1, xcvr_dir is 0 and dout is 0.
- R2: When the idle block samples a valid select on a rising edge, ack_n is low for exactly the following clock cycle.
- R3: An I/O select with any of addr[5:3] set gets no acknowledge, no chip select, no strobe and no transceiver enable.
- R4: A strobed I/O access asserts dac_cs_n[0] for word addresses 0 to 3 and dac_cs_n[1] for word addresses 4 to 7. The chip select lasts one clock and coincides with the acknowledge.
- R5: An I/O write is acknowledged whatever ben_n is. It asserts a chip select and dac_wr_n only when ben_n is 2'b00. I/O reads strobe whatever ben_n is.
- R6: On an I/O access with rd_wr=1 (read), dac_rd_n goes low. With rd_wr=0 (write), dac_wr_n goes low. Each strobe lasts exactly one clock, during the acknowledge cycle.
- R7: An identification read of word index i = addr[4:0] returns 16'h0049, 16'h0050, 16'h0041 and 16'h0043 for i = 0 to 3. It returns the manufacturer code (default 8'hF0) for i = 4, the model code (default 8'h22) for i = 5, and 8'h0C for i = 12. Every other index reads 0. The upper byte is always 0. dout holds the word from the acknowledge cycle until the select is sampled inactive, then returns to 0.
- R8: An identification select with addr[5]=1, or with rd_wr=0, is not acknowledged and leaves dout at 0.
- R9: While the select that started a cycle stays asserted after its acknowledge, there is no further acknowledge or strobe, and dout and xcvr_dir keep their values.
- R10: xcvr_oe_n is low from the acknowledge of an I/O cycle until io_sel_n goes high. It goes high in the same cycle as io_sel_n, without waiting for a clock edge.
- R11: xcvr_dir is loaded at each acknowledged I/O access: 1 (toward the host) for reads, 0 (toward the converters) for writes. Between I/O accesses it keeps its value.
- R12: A cycle in which both selects are low is ignored: no acknowledge, strobe, dout change or transceiver enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 8 MHz bus clock; inputs are sampled on its rising edge |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| io_sel_n | input | 1 | I/O space select, active low |
| id_sel_n | input | 1 | Identification space select, active low |
| rd_wr | input | 1 | 1 = read, 0 = write |
| ben_n | input | 2 | Byte enables, active low, 2'b00 = full word |
| addr | input | ADDR_W (6) | Word address |
| ack_n | output | 1 | Acknowledge, active low |
| dout | output | 16 | Identification read data |
| dac_cs_n | output | NUM_DEV (2) | Converter chip selects, active low |
| dac_rd_n | output | 1 | Converter read strobe, active low |
| dac_wr_n | output | 1 | Converter write strobe, active low |
| xcvr_dir | output | 1 | Transceiver direction, 1 = toward host |
| xcvr_oe_n | output | 1 | Transceiver output enable, active low |

## Verification
Two things can happen in the same cycle: the transceiver enable is released, and a new identification access begins. The bench provokes this by raising io_sel_n in the same cycle as id_sel_n falls while an I/O cycle is being held. xcvr_oe_n must rise in that very cycle, from the select alone. The identification acknowledge must come only after the controller has gone back to idle, two cycles later. A behavioural model of the bus protocol runs alongside the block and judges every output on every clock of this sequence, as it does for all other sequences.

// File: rtl/iobus_slave_pkg.sv
package iobus_slave_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACK  = 2'd1,
    ST_HOLD = 2'd2
  } bus_state_e;

  localparam int DATA_W = 16;

  // Low byte of an identification word; every index not listed reads zero.
  function automatic logic [7:0] id_byte(input int idx,
                                         input logic [7:0] mfr,
                                         input logic [7:0] model);
    logic [7:0] b;
    case (idx)
      0:       b = 8'h49;
      1:       b = 8'h50;
      2:       b = 8'h41;
      3:       b = 8'h43;
      4:       b = mfr;
      5:       b = model;
      12:      b = 8'h0C;
      default: b = 8'h00;
    endcase
    return b;
  endfunction

endpackage

// File: rtl/iobus_addr_decode.sv
module iobus_addr_decode #(
  parameter int ADDR_W  = 6,
  parameter int IO_AW   = 3,
  parameter int LOC_AW  = 2,
  parameter int ID_AW   = 5,
  parameter int NUM_DEV = 2
) (
  input  logic               io_sel_n,
  input  logic               id_sel_n,
  input  logic               rd_wr,
  input  logic [1:0]         ben_n,
  input  logic [ADDR_W-1:0]  addr,
  output logic               io_hit,
  output logic               id_hit,
  output logic               full_xfer,
  output logic [NUM_DEV-1:0] dev_sel
);
  localparam int DEV_W = IO_AW - LOC_AW;

  // A select is valid only when the other space is idle and the upper bits are clear.
  assign io_hit    = !io_sel_n && id_sel_n && (addr[ADDR_W-1:IO_AW] == '0);
  assign id_hit    = !id_sel_n && io_sel_n && rd_wr && (addr[ADDR_W-1:ID_AW] == '0);
  assign full_xfer = rd_wr || (ben_n == 2'b00);

  for (genvar g = 0; g < NUM_DEV; g++) begin : g_dev
    assign dev_sel[g] = (addr[IO_AW-1:LOC_AW] == DEV_W'(g));
  end

endmodule

// File: rtl/iobus_id_pattern.sv
module iobus_id_pattern
  import iobus_slave_pkg::*;
#(
  parameter int         ID_AW      = 5,
  parameter logic [7:0] MFR_CODE   = 8'hF0,
  parameter logic [7:0] MODEL_CODE = 8'h22
) (
  input  logic [ID_AW-1:0]  idx,
  output logic [DATA_W-1:0] word
);
  always_comb begin
    word = '0;
    word[7:0] = id_byte(int'(idx), MFR_CODE, MODEL_CODE);
  end
endmodule

// File: rtl/iobus_slave.sv
module iobus_slave
  import iobus_slave_pkg::*;
#(
  parameter int         ADDR_W       = 6,
  parameter int         NUM_DEV      = 2,
  parameter int         LOCS_PER_DEV = 4,
  parameter int         ID_WORDS     = 32,
  parameter logic [7:0] MFR_CODE     = 8'hF0,
  parameter logic [7:0] MODEL_CODE   = 8'h22
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               io_sel_n,
  input  logic               id_sel_n,
  input  logic               rd_wr,
  input  logic [1:0]         ben_n,
  input  logic [ADDR_W-1:0]  addr,
  output logic               ack_n,
  output logic [15:0]        dout,
  output logic [NUM_DEV-1:0] dac_cs_n,
  output logic               dac_rd_n,
  output logic               dac_wr_n,
  output logic               xcvr_dir,
  output logic               xcvr_oe_n
);
  localparam int LOC_AW = $clog2(LOCS_PER_DEV);
  localparam int IO_AW  = LOC_AW + $clog2(NUM_DEV);
  localparam int ID_AW  = $clog2(ID_WORDS);

  logic               io_hit, id_hit, full_xfer;
  logic [NUM_DEV-1:0] dev_sel;
  logic [DATA_W-1:0]  id_word;

  iobus_addr_decode #(
    .ADDR_W(ADDR_W), .IO_AW(IO_AW), .LOC_AW(LOC_AW),
    .ID_AW(ID_AW), .NUM_DEV(NUM_DEV)
  ) u_dec (
    .io_sel_n(io_sel_n), .id_sel_n(id_sel_n), .rd_wr(rd_wr),
    .ben_n(ben_n), .addr(addr), .io_hit(io_hit), .id_hit(id_hit),
    .full_xfer(full_xfer), .dev_sel(dev_sel)
  );

  iobus_id_pattern #(
    .ID_AW(ID_AW), .MFR_CODE(MFR_CODE), .MODEL_CODE(MODEL_CODE)
  ) u_id (
    .idx(addr[ID_AW-1:0]), .word(id_word)
  );

  bus_state_e         state_q, state_d;
  logic               io_kind_q, io_kind_d;
  logic               ack_q, ack_d;
  logic [NUM_DEV-1:0] cs_q, cs_d;
  logic               rd_q, rd_d, wr_q, wr_d;
  logic               dir_q, dir_d;
  logic               busy_q, busy_d;
  logic [DATA_W-1:0]  dout_q, dout_d;
  logic               dout_en;
  logic               own_sel;

  assign own_sel = io_kind_q ? !io_sel_n : !id_sel_n;

  // Next-state process
  always_comb begin
    state_d   = state_q;
    io_kind_d = io_kind_q;
    ack_d     = 1'b0;
    cs_d      = '0;
    rd_d      = 1'b0;
    wr_d      = 1'b0;
    dir_d     = dir_q;
    busy_d    = busy_q;
    dout_d    = dout_q;
    dout_en   = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (io_hit) begin
          state_d   = ST_ACK;
          io_kind_d = 1'b1;
          ack_d     = 1'b1;
          dir_d     = rd_wr;
          busy_d    = 1'b1;
          if (full_xfer) begin
            cs_d = dev_sel;
            rd_d = rd_wr;
            wr_d = !rd_wr;
          end
        end else if (id_hit) begin
          state_d   = ST_ACK;
          io_kind_d = 1'b0;
          ack_d     = 1'b1;
          dout_d    = id_word;
          dout_en   = 1'b1;
        end
      end
      ST_ACK, ST_HOLD: begin
        if (own_sel) begin
          state_d = ST_HOLD;
        end else begin
          state_d = ST_IDLE;
          busy_d  = 1'b0;
          dout_d  = '0;
          dout_en = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // Register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      io_kind_q <= 1'b0;
      ack_q     <= 1'b0;
      cs_q      <= '0;
      rd_q      <= 1'b0;
      wr_q      <= 1'b0;
      dir_q     <= 1'b0;
      busy_q    <= 1'b0;
      dout_q    <= '0;
    end else begin
      state_q   <= state_d;
      io_kind_q <= io_kind_d;
      ack_q     <= ack_d;
      cs_q      <= cs_d;
      rd_q      <= rd_d;
      wr_q      <= wr_d;
      dir_q     <= dir_d;
      busy_q    <= busy_d;
      if (dout_en) dout_q <= dout_d;
    end
  end

  assign ack_n     = !ack_q;
  assign dac_cs_n  = ~cs_q;
  assign dac_rd_n  = !rd_q;
  assign dac_wr_n  = !wr_q;
  assign xcvr_dir  = dir_q;
  assign dout      = dout_q;
  // Released straight from the select, without waiting for an edge.
  assign xcvr_oe_n = !(busy_q && !io_sel_n);

endmodule

// File: rtl/iobus_slave_chk.sv
module iobus_slave_chk #(
  parameter int ADDR_W  = 6,
  parameter int IO_AW   = 3,
  parameter int NUM_DEV = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               io_sel_n,
  input logic [1:0]         ben_n,
  input logic [ADDR_W-1:0]  addr,
  input logic               ack_n,
  input logic [NUM_DEV-1:0] dac_cs_n,
  input logic               dac_rd_n,
  input logic               dac_wr_n,
  input logic               xcvr_dir,
  input logic               xcvr_oe_n
);
  // R2
  ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_n |=> ack_n);
  // R4
  cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~dac_cs_n));
  // R3
  map_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dac_cs_n != '1) |-> ($past(addr[ADDR_W-1:IO_AW]) == '0));
  // R5
  full_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dac_wr_n |-> ($past(ben_n) == 2'b00));
  // R6
  strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!dac_rd_n || !dac_wr_n) |=> (dac_rd_n && dac_wr_n));
  // R6
  strobe_with_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!dac_rd_n || !dac_wr_n) |-> (!ack_n && ($countones(~dac_cs_n) == 1)));
  // R10
  oe_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    io_sel_n |-> xcvr_oe_n);
  // R11
  dir_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dac_wr_n |-> !xcvr_dir);
endmodule

bind iobus_slave iobus_slave_chk #(
  .ADDR_W(ADDR_W), .IO_AW(IO_AW), .NUM_DEV(NUM_DEV)
) u_chk (
  .clk(clk), .rst_n(rst_n), .io_sel_n(io_sel_n), .ben_n(ben_n),
  .addr(addr), .ack_n(ack_n), .dac_cs_n(dac_cs_n), .dac_rd_n(dac_rd_n),
  .dac_wr_n(dac_wr_n), .xcvr_dir(xcvr_dir), .xcvr_oe_n(xcvr_oe_n)
);

// File: tb/iobus_slave_test.sv
`timescale 1ns/1ps
module iobus_slave_test;
  localparam real HALF = 2.5;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        io_sel_n, id_sel_n, rd_wr;
  logic [1:0]  ben_n;
  logic [5:0]  addr;
  logic        ack_n;
  logic [15:0] dout;
  logic [1:0]  dac_cs_n;
  logic        dac_rd_n, dac_wr_n, xcvr_dir, xcvr_oe_n;

  always #(HALF) clk = ~clk;

  iobus_slave uut (
    .clk(clk), .rst_n(rst_n), .io_sel_n(io_sel_n), .id_sel_n(id_sel_n),
    .rd_wr(rd_wr), .ben_n(ben_n), .addr(addr), .ack_n(ack_n), .dout(dout),
    .dac_cs_n(dac_cs_n), .dac_rd_n(dac_rd_n), .dac_wr_n(dac_wr_n),
    .xcvr_dir(xcvr_dir), .xcvr_oe_n(xcvr_oe_n)
  );

  int    checks = 0;
  int    failures = 0;
  bit    done = 0;
  string cur_req = "R1";

  // Behavioural model of the bus protocol
  int          m_phase;   // 0 idle, 1 acknowledge cycle, 2 waiting for release
  bit          m_io;
  logic        m_ack_n, m_rd_n, m_wr_n, m_dir, m_busy;
  logic [1:0]  m_cs_n;
  logic [15:0] m_dout;

  function automatic logic [15:0] exp_id(input int i);
    logic [15:0] w = 16'h0000;
    if (i == 0) w = 16'h0049;
    else if (i == 1) w = 16'h0050;
    else if (i == 2) w = 16'h0041;
    else if (i == 3) w = 16'h0043;
    else if (i == 4) w = 16'h00F0;
    else if (i == 5) w = 16'h0022;
    else if (i == 12) w = 16'h000C;
    return w;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_phase = 0; m_io = 0; m_ack_n = 1; m_rd_n = 1; m_wr_n = 1;
      m_dir = 0; m_busy = 0; m_cs_n = 2'b11; m_dout = 0;
    end else begin
      m_ack_n = 1; m_rd_n = 1; m_wr_n = 1; m_cs_n = 2'b11;
      if (m_phase == 0) begin
        if (!io_sel_n && id_sel_n && addr < 8) begin
          m_phase = 1; m_io = 1; m_ack_n = 0; m_dir = rd_wr; m_busy = 1;
          if (rd_wr || ben_n == 2'b00) begin
            m_cs_n = (addr < 4) ? 2'b10 : 2'b01;
            if (rd_wr) m_rd_n = 0; else m_wr_n = 0;
          end
        end else if (!id_sel_n && io_sel_n && rd_wr && addr < 32) begin
          m_phase = 1; m_io = 0; m_ack_n = 0; m_dout = exp_id(int'(addr));
        end
      end else begin
        if (m_io ? !io_sel_n : !id_sel_n) m_phase = 2;
        else begin m_phase = 0; m_busy = 0; m_dout = 0; end
      end
    end
  end

  task automatic chk(input string req, input string nm,
                     input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s (%s scenario) %s actual=%h expected=%h at %0t",
               req, cur_req, nm, act, exp, $time);
    end
  endtask

  task automatic cyc(input logic ios, input logic ids, input logic rw,
                     input logic [1:0] be, input logic [5:0] a);
    @(negedge clk);
    io_sel_n = ios; id_sel_n = ids; rd_wr = rw; ben_n = be; addr = a;
    #1;
    chk("R2",  "ack_n",     {15'd0, ack_n},    {15'd0, m_ack_n});
    chk("R4",  "dac_cs_n",  {14'd0, dac_cs_n}, {14'd0, m_cs_n});
    chk("R6",  "dac_rd_n",  {15'd0, dac_rd_n}, {15'd0, m_rd_n});
    chk("R6",  "dac_wr_n",  {15'd0, dac_wr_n}, {15'd0, m_wr_n});
    chk("R10", "xcvr_oe_n", {15'd0, xcvr_oe_n}, {15'd0, !(m_busy && !io_sel_n)});
    chk("R11", "xcvr_dir",  {15'd0, xcvr_dir}, {15'd0, m_dir});
    chk("R7",  "dout",      dout,              m_dout);
  endtask

  task automatic bus(input logic ios, input logic ids, input logic rw,
                     input logic [1:0] be, input logic [5:0] a, input int hold);
    cyc(ios, ids, rw, be, a);
    for (int k = 0; k < hold; k++) cyc(ios, ids, rw, be, a);
    cyc(1'b1, 1'b1, 1'b1, 2'b11, a);
    cyc(1'b1, 1'b1, 1'b1, 2'b11, 6'd0);
  endtask

  initial begin
    rst_n = 0; io_sel_n = 1; id_sel_n = 1; rd_wr = 1; ben_n = 2'b11; addr = 0;
    cur_req = "R1";
    for (int k = 0; k < 3; k++) cyc(1, 1, 1, 2'b11, 6'd0);
    // R1: selects are driven during reset and must be ignored
    cyc(0, 1, 0, 2'b00, 6'd2);
    @(negedge clk); rst_n = 1;
    cyc(1, 1, 1, 2'b11, 6'd0);
    cyc(1, 1, 1, 2'b11, 6'd0);

    cur_req = "R2";
    bus(0, 1, 0, 2'b00, 6'd1, 0);
    cur_req = "R4";
    for (int a = 0; a < 8; a++) bus(0, 1, 1, 2'b00, 6'(a), 0);
    cur_req = "R6";
    bus(0, 1, 0, 2'b00, 6'd5, 1);
    bus(0, 1, 1, 2'b11, 6'd6, 1);
    cur_req = "R5";
    bus(0, 1, 0, 2'b01, 6'd3, 0);
    bus(0, 1, 0, 2'b10, 6'd6, 1);
    bus(0, 1, 1, 2'b01, 6'd2, 0);
    cur_req = "R3";
    bus(0, 1, 0, 2'b00, 6'd8, 1);
    bus(0, 1, 1, 2'b00, 6'h3F, 1);
    bus(0, 1, 1, 2'b00, 6'h20, 0);
    cur_req = "R7";
    for (int a = 0; a < 32; a++) bus(1, 0, 1, 2'b00, 6'(a), 1);
    cur_req = "R8";
    bus(1, 0, 1, 2'b00, 6'd32, 1);
    bus(1, 0, 1, 2'b00, 6'd45, 0);
    bus(1, 0, 0, 2'b00, 6'd0, 1);
    cur_req = "R9";
    bus(0, 1, 0, 2'b00, 6'd4, 6);
    bus(1, 0, 1, 2'b00, 6'd2, 5);
    // R9: other select appears during a held I/O cycle
    cyc(0, 1, 1, 2'b00, 6'd1);
    cyc(0, 1, 1, 2'b00, 6'd1);
    cyc(0, 0, 1, 2'b00, 6'd1);
    cyc(1, 1, 1, 2'b11, 6'd1);
    cyc(1, 1, 1, 2'b11, 6'd0);
    cur_req = "R10";
    cyc(0, 1, 1, 2'b00, 6'd7);
    cyc(0, 1, 1, 2'b00, 6'd7);
    cyc(0, 1, 1, 2'b00, 6'd7);
    cyc(1, 0, 1, 2'b00, 6'd1);
    cyc(1, 0, 1, 2'b00, 6'd1);
    cyc(1, 0, 1, 2'b00, 6'd1);
    cyc(1, 1, 1, 2'b11, 6'd0);
    cyc(1, 1, 1, 2'b11, 6'd0);
    cur_req = "R11";
    bus(0, 1, 1, 2'b00, 6'd0, 0);
    bus(1, 0, 1, 2'b00, 6'd4, 0);
    bus(0, 1, 0, 2'b00, 6'd7, 0);
    cur_req = "R12";
    bus(0, 0, 1, 2'b00, 6'd1, 2);
    bus(0, 0, 0, 2'b00, 6'd4, 1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule